// File: doc/BRIEF.md
# Warp Dispatch Serializer

This block sits between a warp scheduler and one group of identical functional-unit lanes, for example the load/store lanes or the single-precision arithmetic lanes. The scheduler offers one issued warp instruction with a 32-bit mask of active threads. The block splits the warp into slices of as many threads as there are lanes and presents one slice per cycle. Each lane gets an operand-select strobe that tells it to pick up its thread's operands in that cycle.

A warp therefore occupies the lane group for 32 divided by the lane count cycles. This is 1 cycle for a full group of 32 lanes and 32 cycles for a single lane. The block reports this occupancy to the scheduler as a busy flag, so no second instruction for the same unit class can issue while the group is in use. The busy flag drops during the final slice, so the next warp can start in the following cycle with no idle gap.

Each unit class has its own instance. The lane arithmetic and the register-file reads are handled elsewhere.

Top module: `warp_dispatch_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `slot_vld_o`, `done_o` and every bit of `lane_sel_o` are 0.
- R2: An offer (`iss_valid_i` high) is accepted on a rising edge when `busy_o` is low. Slice 0 of the accepted warp is presented in the following cycle.
- R3: A warp is presented over exactly S = 32 / LANES consecutive cycles. `slot_vld_o` is high in each of these cycles, and `slice_idx_o` counts 0, 1, ..., S-1 in order.
- R4: In slice k, `lane_sel_o[i]` equals bit k*LANES+i of the mask captured at acceptance, where mask bit j stands for thread j.
- R5: Inactive threads still take their slot. An all-zero mask occupies S cycles with every strobe low, and it still produces the completion pulse.
- R6: `busy_o` is high in every presented slice except the final one (index S-1), and it is low whenever no slice is presented.
- R7: An offer made while `busy_o` is high is ignored. The slices in progress are unchanged, and no further warp is presented after the final slice.
- R8: An offer accepted during the final slice is followed directly by its slice 0 in the next cycle, with no idle cycle between the two warps.
- R9: `done_o` is high only in the cycle of the final slice (index S-1) of each warp.
- R10: All lane strobes are low in any cycle where no slice is presented.
- R11: The mask is taken only at acceptance. Changes on `iss_mask_i` afterwards do not affect the strobes of the running warp.
- R12: LANES is restricted to 1, 2, 4, 8, 16 or 32. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| iss_valid_i | input | 1 | Scheduler offers a warp instruction |
| iss_mask_i | input | 32 | Active-thread mask, bit j = thread j |
| busy_o | output | 1 | Lane group occupied; a new offer is not accepted |
| slot_vld_o | output | 1 | A slice is presented this cycle |
| slice_idx_o | output | 5 | Index of the presented slice |
| lane_sel_o | output | LANES | Per-lane operand-select strobes |
| done_o | output | 1 | Final slice of a warp is presented |

## Verification
The checker watches several relations on every cycle. It checks that busy is only ever seen inside a non-final slice, that strobes never appear outside a slot, and that done always coincides with the last slice index. It also checks that an accepted offer is followed by slice 0 and that slice indices climb by one. The directed scenarios cover behaviour that depends on mask contents and on what was offered earlier. This includes the exact strobe pattern per slice, an ignored offer during busy that must leave no trace, and a late change of the mask. It also includes back-to-back warps, where both mask contents are visible on consecutive cycles.

// File: rtl/wds_pkg.sv
package wds_pkg;
  localparam int WARP_THREADS = 32;
  localparam int IDX_W        = 5;

  function automatic int slice_count(input int lanes);
    return WARP_THREADS / lanes;
  endfunction

  function automatic bit lanes_legal(input int lanes);
    return (lanes == 1) || (lanes == 2) || (lanes == 4) ||
           (lanes == 8) || (lanes == 16) || (lanes == 32);
  endfunction
endpackage

// File: rtl/wds_slice_ctr.sv
module wds_slice_ctr #(
  parameter int SLICES = 4,
  localparam int SW = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [SW-1:0] cnt,
  output logic          last
);
  logic          active_d;
  logic [SW-1:0] cnt_d;
  logic          cnt_en;

  assign last = active && (cnt == SW'(SLICES - 1));

  always_comb begin
    active_d = active;
    cnt_d    = cnt;
    cnt_en   = 1'b0;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
      cnt_en   = 1'b1;
    end else if (active) begin
      cnt_en = 1'b1;
      if (last) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (cnt_en) begin
      active <= active_d;
      cnt    <= cnt_d;
    end
  end
endmodule

// File: rtl/wds_mask_hold.sv
module wds_mask_hold #(
  parameter int LANES = 8,
  parameter int SW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      mask_in,
  input  logic [SW-1:0]    cnt,
  output logic [LANES-1:0] slice_bits
);
  logic [31:0] mask_q;
  logic [31:0] shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= mask_in;
    end
  end

  always_comb begin
    shifted    = mask_q >> (int'(cnt) * LANES);
    slice_bits = shifted[LANES-1:0];
  end
endmodule

// File: rtl/wds_lane_drive.sv
module wds_lane_drive #(
  parameter int LANES = 8
) (
  input  logic             slot,
  input  logic [LANES-1:0] slice_bits,
  output logic [LANES-1:0] lane_sel
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_sel[i] = slot & slice_bits[i];
  end
endmodule

// File: rtl/warp_dispatch_serializer.sv
module warp_dispatch_serializer
  import wds_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid_i,
  input  logic [31:0]      iss_mask_i,
  output logic             busy_o,
  output logic             slot_vld_o,
  output logic [4:0]       slice_idx_o,
  output logic [LANES-1:0] lane_sel_o,
  output logic             done_o
);
  localparam int SLICES = slice_count(LANES);
  localparam int SW     = (SLICES > 1) ? $clog2(SLICES) : 1;

  // R12: only power-of-two lane counts that divide a warp evenly
  if (!lanes_legal(LANES)) begin : g_bad_lanes
    $error("LANES must be 1, 2, 4, 8, 16 or 32");
  end

  logic          accept;
  logic          active;
  logic          last;
  logic [SW-1:0] cnt;
  logic [LANES-1:0] slice_bits;

  assign accept = iss_valid_i && !busy_o;

  wds_slice_ctr #(.SLICES(SLICES)) i_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .active (active),
    .cnt    (cnt),
    .last   (last)
  );

  wds_mask_hold #(.LANES(LANES), .SW(SW)) i_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .mask_in    (iss_mask_i),
    .cnt        (cnt),
    .slice_bits (slice_bits)
  );

  wds_lane_drive #(.LANES(LANES)) i_drive (
    .slot       (active),
    .slice_bits (slice_bits),
    .lane_sel   (lane_sel_o)
  );

  assign busy_o      = active && !last;
  assign slot_vld_o  = active;
  assign slice_idx_o = IDX_W'(cnt);
  assign done_o      = last;
endmodule

// File: rtl/wds_checker.sv
module wds_checker #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid_i,
  input logic [31:0]      iss_mask_i,
  input logic             busy_o,
  input logic             slot_vld_o,
  input logic [4:0]       slice_idx_o,
  input logic [LANES-1:0] lane_sel_o,
  input logic             done_o
);
  localparam logic [4:0] LAST_IDX = 5'(32 / LANES - 1);

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld_o |-> (lane_sel_o == '0));

  // R6
  busy_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (slot_vld_o && slice_idx_o != LAST_IDX));

  // R9
  done_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (slot_vld_o && slice_idx_o == LAST_IDX));

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_i && !busy_o) |=> (slot_vld_o && slice_idx_o == 5'd0));

  // R3
  slice_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld_o && slice_idx_o != LAST_IDX) |=>
      (slot_vld_o && slice_idx_o == $past(slice_idx_o) + 5'd1));

  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> slot_vld_o);
endmodule

bind warp_dispatch_serializer wds_checker #(.LANES(LANES)) i_wds_checker (.*);

// File: tb/test_warp_dispatch_serializer.sv
module test_warp_dispatch_serializer;
  localparam int LANES  = 8;
  localparam int SLICES = 32 / LANES;

  logic             clk;
  logic             rst_n;
  logic             iss_valid_i;
  logic [31:0]      iss_mask_i;
  logic             busy_o;
  logic             slot_vld_o;
  logic [4:0]       slice_idx_o;
  logic [LANES-1:0] lane_sel_o;
  logic             done_o;

  int n_checks = 0;
  int n_fail   = 0;

  warp_dispatch_serializer #(.LANES(LANES)) i_warp_dispatch_serializer (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "slot", 32'(slot_vld_o), 32'd0);
    chk(req, "busy", 32'(busy_o), 32'd0);
    chk(req, "done", 32'(done_o), 32'd0);
    chk(req, "strobes", 32'(lane_sel_o), 32'd0);
  endtask

  // Called at the negedge where slice 0 of mask m is visible.
  // mode 0: plain; mode 1: offer nxt during final slice; mode 2: offer nxt while busy.
  task automatic watch(input logic [31:0] m, input string req,
                       input int mode, input logic [31:0] nxt);
    for (int k = 0; k < SLICES; k++) begin
      logic [31:0] exp_bits;
      exp_bits = (m >> (k * LANES)) & ((32'd1 << LANES) - 32'd1);
      chk(req, "slot", 32'(slot_vld_o), 32'd1);
      chk("R3", "slice index", 32'(slice_idx_o), 32'(k));
      chk("R4", "strobes", 32'(lane_sel_o), exp_bits);
      chk("R6", "busy", 32'(busy_o), 32'(k != SLICES - 1));
      chk("R9", "done", 32'(done_o), 32'(k == SLICES - 1));
      if (k == 0 && mode == 0) iss_mask_i = ~m;            // R11 late mask change
      if (mode == 2 && k == 1) begin iss_valid_i = 1'b1; iss_mask_i = nxt; end
      if (mode == 2 && k == SLICES - 1) iss_valid_i = 1'b0;
      if (mode == 1 && k == SLICES - 1) begin iss_valid_i = 1'b1; iss_mask_i = nxt; end
      @(negedge clk);
    end
    iss_valid_i = 1'b0;
  endtask

  task automatic issue(input logic [31:0] m);
    iss_valid_i = 1'b1;
    iss_mask_i  = m;
    @(negedge clk);
    iss_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_idle("R1");
    @(negedge clk);
    chk_idle("R1");
  endtask

  task automatic t_full;
    issue(32'hFFFF_FFFF);
    watch(32'hFFFF_FFFF, "R2", 0, 32'd0);
    chk_idle("R10");
  endtask

  task automatic t_pattern;
    issue(32'hA5C3_0F81);
    watch(32'hA5C3_0F81, "R11", 0, 32'd0);
    chk_idle("R10");
  endtask

  task automatic t_empty;
    issue(32'h0000_0000);
    watch(32'h0000_0000, "R5", 0, 32'd0);
    chk_idle("R5");
  endtask

  task automatic t_ignore;
    issue(32'h1234_5678);
    watch(32'h1234_5678, "R7", 2, 32'hFFFF_FFFF);
    chk_idle("R7");
    @(negedge clk);
    chk_idle("R7");
  endtask

  task automatic t_b2b;
    issue(32'h0F0F_F0F0);
    watch(32'h0F0F_F0F0, "R8", 1, 32'h8001_7E42);
    watch(32'h8001_7E42, "R8", 0, 32'd0);
    chk_idle("R8");
  endtask

  initial begin
    rst_n       = 1'b0;
    iss_valid_i = 1'b0;
    iss_mask_i  = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_pattern();
    t_empty();
    t_ignore();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule